// File: doc/BRIEF.md
# Masking PRNG Reseed Scheduler

This block sits beside the masking pseudo-random generator of a block cipher unit and decides when that generator takes fresh entropy and whether it steps forward. It counts completed cipher blocks and raises a reseed request once a programmable number of them has passed. It also raises a request when the key is replaced, if that option is on, and when software asks for a reseed directly. Requests go to an entropy source over a level request / acknowledge handshake. While a request is outstanding the block reports busy, so the cipher holds back its next launch.

A debug option stops the masking generator from stepping, which keeps the masks constant. A sticky lock bit makes the key-change option and the debug option read-only until reset. The interval field is written with every configuration write, and the lock does not cover it.

Top module: `mask_reseed_sched`

## Requirements
- R1: The 3-bit interval code `cfg_rate` is one-hot. Value 3'b001 requests a reseed after every completed block. Value 3'b010 requests one after every INTV_MID (default 64) blocks. Value 3'b100 requests one after every INTV_LONG (default 8192) blocks. The request is raised on the clock edge that takes in the last block of the interval.
- R2: Any `cfg_rate` value that is not one-hot (for example 3'b000 or 3'b011) behaves as the INTV_LONG interval, and `rate_err` is high while such a value is stored.
- R3: The block counter returns to zero on every configuration write and on every reseed, whatever caused the reseed. A block that arrives in the same cycle as a configuration write is not counted.
- R4: When `key_reseed_en` is high, a `key_change` pulse raises a reseed request with `reseed_clear` high, which asks for the clearing generator to be reseeded as well. When `key_reseed_en` is low, `key_change` has no effect.
- R5: A `sw_reseed` pulse raises a reseed request on the next edge. If no key-change trigger joins that request, `reseed_clear` stays low.
- R6: Once `ent_req` is high it stays high until a cycle in which `ent_ack` is high. It then drops on the following edge, unless a new trigger arrives in that same cycle. `reseed_busy` is high exactly while `ent_req` is high.
- R7: Triggers that arrive while a request is outstanding merge into it, so the whole group is served by a single acknowledge. A block-interval trigger and a software trigger that fall in the same cycle also give one request.
- R8: `mask_step` follows `block_done` while `masks_frozen` is low, and stays low while `masks_frozen` is high.
- R9: Writing `cfg_lock` as 1 sets `aux_locked`. The bit can only be set, and only reset clears it. While it is set, configuration writes leave `key_reseed_en` and `masks_frozen` unchanged but still update the interval code.
- R10: After reset, `ent_req`, `reseed_busy`, `reseed_clear`, `rate_err`, `key_reseed_en`, `masks_frozen` and `aux_locked` are all low, and the interval code is 3'b001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rate | input | 3 | Interval code written on `cfg_we` |
| cfg_key_reseed | input | 1 | Reseed-on-key-change value written on `cfg_we` |
| cfg_freeze | input | 1 | Constant-mask value written on `cfg_we` |
| cfg_lock | input | 1 | Sets the auxiliary lock when written as 1 |
| block_done | input | 1 | One-cycle pulse per completed cipher block |
| key_change | input | 1 | One-cycle pulse when a new key is installed |
| sw_reseed | input | 1 | One-cycle software reseed trigger |
| ent_ack | input | 1 | Entropy source acknowledge |
| ent_req | output | 1 | Reseed request to the entropy source |
| reseed_clear | output | 1 | Outstanding request also covers the clearing generator |
| reseed_busy | output | 1 | Reseed pending; defer cipher launch |
| mask_step | output | 1 | Advance the masking generator this cycle |
| rate_err | output | 1 | Stored interval code is not one-hot |
| key_reseed_en | output | 1 | Current reseed-on-key-change setting |
| masks_frozen | output | 1 | Current constant-mask setting |
| aux_locked | output | 1 | Auxiliary lock state |

## Verification
Two things can fall in the same cycle: the block pulse that closes an interval, and a software reseed pulse. The bench drives 63 blocks at the 64-block interval and then asserts `block_done` and `sw_reseed` together on the 64th. It expects exactly one acknowledge. A further 63 blocks must then raise no request, which shows the counter was cleared only once and not counted twice. Merging of a key-change trigger into a pending request is tested by holding the acknowledge off while several triggers arrive. The bench then expects `reseed_clear` high and a single acknowledge once the responder is released.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    localparam int RATE_W = 3;

    localparam logic [RATE_W-1:0] RATE_EVERY = 3'b001;
    localparam logic [RATE_W-1:0] RATE_MID   = 3'b010;
    localparam logic [RATE_W-1:0] RATE_LONG  = 3'b100;

    typedef enum logic [1:0] {
        SEL_ONE  = 2'd0,
        SEL_MID  = 2'd1,
        SEL_LONG = 2'd2
    } intv_sel_e;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              key_reseed;
        logic              freeze;
        logic              locked;
    } aux_cfg_t;

    function automatic logic rate_is_valid(logic [RATE_W-1:0] r);
        return (r == RATE_EVERY) || (r == RATE_MID) || (r == RATE_LONG);
    endfunction

    function automatic intv_sel_e rate_decode(logic [RATE_W-1:0] r);
        intv_sel_e s;
        case (r)
            RATE_EVERY: s = SEL_ONE;
            RATE_MID:   s = SEL_MID;
            default:    s = SEL_LONG;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mrs_aux_regs.sv
module mrs_aux_regs
    import mrs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [RATE_W-1:0] rate_in,
    input  logic              key_reseed_in,
    input  logic              freeze_in,
    input  logic              lock_in,
    output aux_cfg_t          cfg
);

    aux_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.rate       <= RATE_EVERY;
            cfg_q.key_reseed <= 1'b0;
            cfg_q.freeze     <= 1'b0;
            cfg_q.locked     <= 1'b0;
        end else if (we) begin
            cfg_q.rate <= rate_in;
            if (!cfg_q.locked) begin
                cfg_q.key_reseed <= key_reseed_in;
                cfg_q.freeze     <= freeze_in;
            end
            cfg_q.locked <= cfg_q.locked | lock_in;
        end
    end

    assign cfg = cfg_q;

    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_q.locked |=> cfg_q.locked);

    // R9
    lock_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_q.locked |=> ($stable(cfg_q.key_reseed) && $stable(cfg_q.freeze)));

endmodule

// File: rtl/mrs_block_counter.sv
module mrs_block_counter
    import mrs_pkg::*;
#(
    parameter int INTV_MID  = 64,
    parameter int INTV_LONG = 8192
) (
    input  logic      clk,
    input  logic      rst,
    input  intv_sel_e sel,
    input  logic      tick,
    input  logic      clr_cfg,
    input  logic      clr_trig,
    output logic      hit
);

    localparam int CNT_W = (INTV_LONG > 1) ? $clog2(INTV_LONG) : 1;
    localparam logic [CNT_W:0] LIM_ONE  = (CNT_W+1)'(1);
    localparam logic [CNT_W:0] LIM_MID  = (CNT_W+1)'(INTV_MID);
    localparam logic [CNT_W:0] LIM_LONG = (CNT_W+1)'(INTV_LONG);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   limit;

    always_comb begin
        case (sel)
            SEL_ONE: limit = LIM_ONE;
            SEL_MID: limit = LIM_MID;
            default: limit = LIM_LONG;
        endcase
    end

    assign hit = tick && !clr_cfg && ({1'b0, cnt_q} == (limit - 1'b1));

    always_ff @(posedge clk) begin
        if (rst || clr_cfg || clr_trig || hit) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        {1'b0, cnt_q} < limit);

    // R3
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_cfg || clr_trig) |=> (cnt_q == '0));

endmodule

// File: rtl/mrs_req_ctrl.sv
module mrs_req_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic trig_rate,
    input  logic trig_sw,
    input  logic trig_key,
    input  logic ack,
    output logic req,
    output logic clr_also
);

    logic any_trig;
    logic req_q;
    logic clr_q;

    assign any_trig = trig_rate | trig_sw | trig_key;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            clr_q <= 1'b0;
        end else if (req_q && ack) begin
            req_q <= any_trig;
            clr_q <= trig_key;
        end else begin
            req_q <= req_q | any_trig;
            clr_q <= clr_q | trig_key;
        end
    end

    assign req      = req_q;
    assign clr_also = clr_q;

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q && !ack) |=> req_q);

    // R6
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q && ack && !any_trig) |=> !req_q);

    // R4
    clr_with_req_chk: assert property (@(posedge clk) disable iff (rst)
        clr_q |-> req_q);

endmodule

// File: rtl/mask_reseed_sched.sv
module mask_reseed_sched
    import mrs_pkg::*;
#(
    parameter int INTV_MID  = 64,
    parameter int INTV_LONG = 8192
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [2:0] cfg_rate,
    input  logic       cfg_key_reseed,
    input  logic       cfg_freeze,
    input  logic       cfg_lock,
    input  logic       block_done,
    input  logic       key_change,
    input  logic       sw_reseed,
    input  logic       ent_ack,
    output logic       ent_req,
    output logic       reseed_clear,
    output logic       reseed_busy,
    output logic       mask_step,
    output logic       rate_err,
    output logic       key_reseed_en,
    output logic       masks_frozen,
    output logic       aux_locked
);

    aux_cfg_t cfg;
    logic     trig_key;
    logic     trig_rate;

    mrs_aux_regs u_aux (
        .clk           (clk),
        .rst           (rst),
        .we            (cfg_we),
        .rate_in       (cfg_rate),
        .key_reseed_in (cfg_key_reseed),
        .freeze_in     (cfg_freeze),
        .lock_in       (cfg_lock),
        .cfg           (cfg)
    );

    assign trig_key = key_change & cfg.key_reseed;

    mrs_block_counter #(
        .INTV_MID  (INTV_MID),
        .INTV_LONG (INTV_LONG)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .sel      (rate_decode(cfg.rate)),
        .tick     (block_done),
        .clr_cfg  (cfg_we),
        .clr_trig (sw_reseed | trig_key),
        .hit      (trig_rate)
    );

    mrs_req_ctrl u_req (
        .clk       (clk),
        .rst       (rst),
        .trig_rate (trig_rate),
        .trig_sw   (sw_reseed),
        .trig_key  (trig_key),
        .ack       (ent_ack),
        .req       (ent_req),
        .clr_also  (reseed_clear)
    );

    assign reseed_busy   = ent_req;
    assign mask_step     = block_done & ~cfg.freeze;
    assign rate_err      = ~rate_is_valid(cfg.rate);
    assign key_reseed_en = cfg.key_reseed;
    assign masks_frozen  = cfg.freeze;
    assign aux_locked    = cfg.locked;

    // R5
    sw_req_chk: assert property (@(posedge clk) disable iff (rst)
        sw_reseed |=> ent_req);

    // R8
    frozen_no_step_chk: assert property (@(posedge clk) disable iff (rst)
        masks_frozen |-> !mask_step);

endmodule

// File: tb/mask_reseed_sched_bench.sv
module mask_reseed_sched_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_rate = 3'b001;
    logic       cfg_key_reseed = 1'b0;
    logic       cfg_freeze = 1'b0;
    logic       cfg_lock = 1'b0;
    logic       block_done = 1'b0;
    logic       key_change = 1'b0;
    logic       sw_reseed = 1'b0;
    logic       ent_ack = 1'b0;
    logic       ent_req, reseed_clear, reseed_busy, mask_step;
    logic       rate_err, key_reseed_en, masks_frozen, aux_locked;

    int checks = 0;
    int errors = 0;
    int acks = 0;
    int wait_cnt = 0;
    logic resp_en = 1'b1;

    always #2.5 clk = ~clk;

    mask_reseed_sched u_mask_reseed_sched (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_rate(cfg_rate),
        .cfg_key_reseed(cfg_key_reseed), .cfg_freeze(cfg_freeze),
        .cfg_lock(cfg_lock), .block_done(block_done), .key_change(key_change),
        .sw_reseed(sw_reseed), .ent_ack(ent_ack), .ent_req(ent_req),
        .reseed_clear(reseed_clear), .reseed_busy(reseed_busy),
        .mask_step(mask_step), .rate_err(rate_err),
        .key_reseed_en(key_reseed_en), .masks_frozen(masks_frozen),
        .aux_locked(aux_locked)
    );

    // entropy source model: acknowledge two negedges after seeing a request
    always @(negedge clk) begin
        if (ent_ack) begin
            ent_ack <= 1'b0;
        end else if (ent_req && resp_en && !rst) begin
            if (wait_cnt >= 1) begin
                ent_ack  <= 1'b1;
                acks     <= acks + 1;
                wait_cnt <= 0;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(logic [2:0] r, logic k, logic f, logic l);
        @(negedge clk);
        cfg_we = 1'b1; cfg_rate = r; cfg_key_reseed = k; cfg_freeze = f; cfg_lock = l;
        @(negedge clk);
        cfg_we = 1'b0; cfg_lock = 1'b0;
    endtask

    task automatic blocks(int n, int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); block_done = 1'b1;
            @(negedge clk); block_done = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic pulse_sw();
        @(negedge clk); sw_reseed = 1'b1;
        @(negedge clk); sw_reseed = 1'b0;
    endtask

    task automatic settle();
        repeat (10) @(negedge clk);
    endtask

    localparam int NV = 7;
    localparam logic [2:0] V_RATE [NV] = '{3'b001, 3'b010, 3'b010, 3'b010, 3'b100, 3'b011, 3'b000};
    localparam int         V_N    [NV] = '{5, 64, 63, 130, 100, 100, 10};
    localparam int         V_REQ  [NV] = '{5, 1, 0, 2, 0, 0, 0};
    localparam int         V_ERR  [NV] = '{0, 0, 0, 0, 0, 1, 1};

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R10 reset state
        chk("R10 ent_req", int'(ent_req), 0);
        chk("R10 busy", int'(reseed_busy), 0);
        chk("R10 clear", int'(reseed_clear), 0);
        chk("R10 rate_err", int'(rate_err), 0);
        chk("R10 key_en", int'(key_reseed_en), 0);
        chk("R10 frozen", int'(masks_frozen), 0);
        chk("R10 locked", int'(aux_locked), 0);

        // R1 R2 table walk
        for (int v = 0; v < NV; v++) begin
            cfg_write(V_RATE[v], 1'b0, 1'b0, 1'b0);
            acks = 0;
            blocks(V_N[v], 6);
            settle();
            chk("R1 requests", acks, V_REQ[v]);
            chk("R2 rate_err", int'(rate_err), V_ERR[v]);
        end

        // R1 long interval boundary
        cfg_write(3'b100, 1'b0, 1'b0, 1'b0);
        acks = 0;
        blocks(8191, 1);
        settle();
        chk("R1 long 8191", acks, 0);
        blocks(1, 6);
        settle();
        chk("R1 long 8192", acks, 1);

        // R2 invalid code behaves as long interval
        cfg_write(3'b000, 1'b0, 1'b0, 1'b0);
        acks = 0;
        blocks(8191, 1);
        settle();
        chk("R2 invalid 8191", acks, 0);
        blocks(1, 6);
        settle();
        chk("R2 invalid 8192", acks, 1);

        // R3 rate rewrite clears counter
        cfg_write(3'b010, 1'b0, 1'b0, 1'b0);
        acks = 0;
        blocks(40, 2);
        cfg_write(3'b010, 1'b0, 1'b0, 1'b0);
        blocks(40, 2);
        settle();
        chk("R3 rewrite clears", acks, 0);
        blocks(24, 6);
        settle();
        chk("R3 after rewrite", acks, 1);

        // R3 R5 software reseed clears counter, no clear flag
        cfg_write(3'b010, 1'b0, 1'b0, 1'b0);
        acks = 0;
        blocks(50, 2);
        @(negedge clk); sw_reseed = 1'b1;
        @(negedge clk); sw_reseed = 1'b0; #1;
        chk("R5 sw req", int'(ent_req), 1);
        chk("R5 sw clear low", int'(reseed_clear), 0);
        settle();
        chk("R5 sw ack", acks, 1);
        chk("R6 req dropped", int'(ent_req), 0);
        blocks(50, 2);
        settle();
        chk("R3 sw clears counter", acks, 1);
        blocks(14, 6);
        settle();
        chk("R3 after sw", acks, 2);

        // R4 key change without enable
        cfg_write(3'b010, 1'b0, 1'b0, 1'b0);
        acks = 0;
        @(negedge clk); key_change = 1'b1;
        @(negedge clk); key_change = 1'b0;
        settle();
        chk("R4 key disabled", acks, 0);

        // R4 key change with enable
        cfg_write(3'b010, 1'b1, 1'b0, 1'b0);
        acks = 0;
        @(negedge clk); key_change = 1'b1;
        @(negedge clk); key_change = 1'b0; #1;
        chk("R4 key req", int'(ent_req), 1);
        chk("R4 key clear", int'(reseed_clear), 1);
        settle();
        chk("R4 key ack", acks, 1);
        chk("R4 clear dropped", int'(reseed_clear), 0);

        // R6 R7 merging while acknowledge is held off
        resp_en = 1'b0;
        acks = 0;
        pulse_sw();
        pulse_sw();
        @(negedge clk); key_change = 1'b1;
        @(negedge clk); key_change = 1'b0;
        repeat (5) @(negedge clk); #1;
        chk("R6 req held", int'(ent_req), 1);
        chk("R6 busy held", int'(reseed_busy), 1);
        chk("R7 merged clear", int'(reseed_clear), 1);
        resp_en = 1'b1;
        settle();
        chk("R7 single ack", acks, 1);
        chk("R6 busy released", int'(reseed_busy), 0);

        // R7 interval hit and software trigger in the same cycle
        cfg_write(3'b010, 1'b0, 1'b0, 1'b0);
        acks = 0;
        blocks(63, 2);
        @(negedge clk); block_done = 1'b1; sw_reseed = 1'b1;
        @(negedge clk); block_done = 1'b0; sw_reseed = 1'b0;
        settle();
        chk("R7 same cycle one req", acks, 1);
        blocks(63, 2);
        settle();
        chk("R7 counter cleared once", acks, 1);

        // R8 mask stepping
        cfg_write(3'b100, 1'b0, 1'b0, 1'b0);
        @(negedge clk); block_done = 1'b1; #1;
        chk("R8 step when free", int'(mask_step), 1);
        @(negedge clk); block_done = 1'b0;
        cfg_write(3'b100, 1'b0, 1'b1, 1'b0);
        @(negedge clk); block_done = 1'b1; #1;
        chk("R8 no step frozen", int'(mask_step), 0);
        @(negedge clk); block_done = 1'b0;

        // R9 lock
        cfg_write(3'b100, 1'b0, 1'b1, 1'b1);
        #1;
        chk("R9 locked", int'(aux_locked), 1);
        cfg_write(3'b010, 1'b1, 1'b0, 1'b0);
        #1;
        chk("R9 locked sticky", int'(aux_locked), 1);
        chk("R9 key_en held", int'(key_reseed_en), 0);
        chk("R9 freeze held", int'(masks_frozen), 1);
        acks = 0;
        blocks(64, 6);
        settle();
        chk("R9 rate still writable", acks, 1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        chk("R9 reset clears lock", int'(aux_locked), 0);
        chk("R9 reset clears freeze", int'(masks_frozen), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule